// File: doc/BRIEF.md
# Receive Status Queue with Peek and Pop Read Ports

This block keeps a small first-in first-out queue of status words for the receive side of a USB host controller. Whenever the receive logic finishes an event, it pushes one entry. The entry carries a packet status code, the data PID, the received byte count and the channel number. Software reaches the queue through a simple 32-bit register port. Reading one offset returns the oldest entry and leaves the queue as it was. Reading a second offset returns the same entry and also removes it.

A non-empty output tells software when there is something to read. When software pops an entry whose status reports a completed transfer, a toggle error or a halted channel, the block emits a one-cycle interrupt pulse and sets a sticky pending bit. A sticky overflow bit records pushes that were lost because the queue was full. Both sticky bits are read, and cleared by writing 1, at a third offset.

Top module: `rx_event_queue`

## Requirements
- R1: A full-word read at offset 0x1C returns the head entry on regRdata in the cycle after the access, and it leaves the queue contents and occupancy unchanged.
- R2: A full-word read at offset 0x20 returns the head entry in the cycle after the access and removes that entry from the queue.
- R3: The returned word holds the status in bits 20:17, the data PID in bits 16:15 (00 = DATA0, 10 = DATA1, 01 = DATA2, passed through unchanged), the byte count in bits 14:4 and the channel in bits 3:0. Bits 31:21 always read as zero.
- R4: Popping an entry with status 0011, 0101 or 0111 drives popIrq high for exactly the cycle after the access and sets irqPending. Popping status 0010 or any reserved code does neither.
- R5: The flag register at offset 0x24 reads irqPending in bit 0 and overflowFlag in bit 1. Writing a 1 to bit 0 clears irqPending. Writing 0 there has no effect.
- R6: notEmpty is high exactly while the queue holds at least one entry.
- R7: A pop while the queue is empty returns 0, raises no interrupt and leaves the queue unchanged.
- R8: A push while the queue is full and no pop happens in the same cycle is dropped and sets overflowFlag. Writing a 1 to bit 1 at offset 0x24 clears overflowFlag.
- R9: A push and a pop in the same cycle leave the occupancy unchanged. This holds when the queue is full too, where the push is accepted.
- R10: An access whose byte enables are not all 1 (4'hF) is ignored: a read returns 0 and pops nothing, and a write changes no flag.
- R11: After reset the queue is empty, and regRdata, popIrq, irqPending and overflowFlag are all 0.
- R12: Entries come out in the order they were pushed. The queue holds up to DEPTH entries (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push one status entry this cycle |
| pushStatus | input | 4 | Packet status code of the pushed entry |
| pushPid | input | 2 | Data PID of the pushed entry |
| pushByteCount | input | 11 | Received byte count of the pushed entry |
| pushChannel | input | 4 | Channel number of the pushed entry |
| regSel | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset of the access |
| regByteEn | input | 4 | Byte enables; only 4'hF is accepted |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| notEmpty | output | 1 | Queue holds at least one entry |
| popIrq | output | 1 | One-cycle pulse after an interrupting pop |
| irqPending | output | 1 | Sticky pop interrupt, write 1 to clear |
| overflowFlag | output | 1 | Sticky dropped-push flag, write 1 to clear |

## Verification
The bench walks a table of entries that covers every status class and the extreme field values, so bit packing and pop order are checked word for word. It also checks that the interrupt pulse follows only the three interrupting codes: a design that decoded the codes wrongly would pulse on data or reserved entries, or stay silent on a halted channel. Further tests target popping an empty queue, pushing into a full one, a push and a pop in the same cycle both at the full mark and one entry deep, and partial byte-enable accesses. A design that got these wrong would return stale data, corrupt its pointers, wrongly drop or accept the overlapping push, or pop on a malformed read. The sticky bits are cleared one at a time, which shows that each write-1 affects only its own bit.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Packed status entry, most significant field first (bits 20:0 of the word)
  typedef struct packed {
    logic [3:0]  pktStatus;
    logic [1:0]  dataPid;
    logic [10:0] byteCount;
    logic [3:0]  chanNum;
  } rxEntry_t;

  localparam int ENTRY_W = $bits(rxEntry_t);
  localparam int DATA_W  = 32;

  localparam logic [7:0] OFF_PEEK  = 8'h1C;
  localparam logic [7:0] OFF_POP   = 8'h20;
  localparam logic [7:0] OFF_FLAGS = 8'h24;

  localparam logic [3:0] ST_IN_DATA    = 4'b0010;
  localparam logic [3:0] ST_XFER_DONE  = 4'b0011;
  localparam logic [3:0] ST_TOGGLE_ERR = 4'b0101;
  localparam logic [3:0] ST_CHAN_HALT  = 4'b0111;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_HEAD  = 2'd1,
    RD_FLAGS = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   pushEn;
    logic   popEn;
    rdSel_e rdSel;
  } qStrobe_t;

  function automatic logic isIrqStatus(input logic [3:0] st);
    return (st == ST_XFER_DONE) || (st == ST_TOGGLE_ERR) || (st == ST_CHAN_HALT);
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  rxEntry_t          pushEntry,
  input  logic [1:0]        flagBits,
  output logic [CNT_W-1:0]  count,
  output rxEntry_t          headEntry,
  output logic [DATA_W-1:0] rdata
);

  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W-1:0] wrPtrNext, rdPtrNext;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrPtrNext = wrPtr + 1'b1;
      assign rdPtrNext = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrPtrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.pushEn) mem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.pushEn) wrPtr <= wrPtrNext;
      if (strobe.popEn)  rdPtr <= rdPtrNext;
      case ({strobe.pushEn, strobe.popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else begin
      case (strobe.rdSel)
        RD_HEAD:  rdata <= (count == '0) ? '0 : {{(DATA_W - ENTRY_W){1'b0}}, headEntry};
        RD_FLAGS: rdata <= {{(DATA_W - 2){1'b0}}, flagBits};
        default:  rdata <= '0;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R12
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popEn |-> count != '0); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && !strobe.popEn) |-> count < CNT_W'(DEPTH)); // R8
  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && strobe.popEn) |=> count == $past(count)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdata[DATA_W-1:ENTRY_W] == '0); // R3

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [1:0]        clearBits,
  input  logic [CNT_W-1:0]  count,
  input  logic [3:0]        headStatus,
  output qStrobe_t          strobe,
  output logic [1:0]        flagBits,
  output logic              notEmpty,
  output logic              popIrq,
  output logic              irqPending,
  output logic              overflowFlag
);

  logic wordAcc, rdPeek, rdPop, rdFlags, wrFlags;
  logic isEmpty, isFull, popGo, dropPush, irqHit;

  assign wordAcc = regSel && (regByteEn == 4'hF);
  assign rdPeek  = wordAcc && !regWrite && (regAddr == ADDR_W'(OFF_PEEK));
  assign rdPop   = wordAcc && !regWrite && (regAddr == ADDR_W'(OFF_POP));
  assign rdFlags = wordAcc && !regWrite && (regAddr == ADDR_W'(OFF_FLAGS));
  assign wrFlags = wordAcc &&  regWrite && (regAddr == ADDR_W'(OFF_FLAGS));

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNT_W'(DEPTH));
  assign popGo    = rdPop && !isEmpty;
  assign dropPush = pushValid && isFull && !popGo;
  assign irqHit   = popGo && isIrqStatus(headStatus);

  always_comb begin
    strobe.pushEn = pushValid && (!isFull || popGo);
    strobe.popEn  = popGo;
    if (rdPeek || rdPop) strobe.rdSel = RD_HEAD;
    else if (rdFlags)    strobe.rdSel = RD_FLAGS;
    else                 strobe.rdSel = RD_NONE;
  end

  assign notEmpty = !isEmpty;
  assign flagBits = {overflowFlag, irqPending};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popIrq       <= 1'b0;
      irqPending   <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      popIrq <= irqHit;
      if (irqHit)                       irqPending <= 1'b1;
      else if (wrFlags && clearBits[0]) irqPending <= 1'b0;
      if (dropPush)                     overflowFlag <= 1'b1;
      else if (wrFlags && clearBits[1]) overflowFlag <= 1'b0;
    end
  end

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (rdPeek && !pushValid) |=> count == $past(count)); // R1
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    popIrq |-> irqPending); // R4
  AST_EMPTY_POP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && isEmpty) |=> !popIrq); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    dropPush |=> overflowFlag); // R8
  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regByteEn != 4'hF && !pushValid) |=> count == $past(count)); // R10

endmodule

// File: rtl/rx_event_queue.sv
module rx_event_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [3:0]        pushStatus,
  input  logic [1:0]        pushPid,
  input  logic [10:0]       pushByteCount,
  input  logic [3:0]        pushChannel,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              notEmpty,
  output logic              popIrq,
  output logic              irqPending,
  output logic              overflowFlag
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  qStrobe_t         strobe;
  rxEntry_t         pushEntry, headEntry;
  logic [CNT_W-1:0] count;
  logic [1:0]       flagBits;
  logic             unusedWdata;

  assign pushEntry   = '{pktStatus: pushStatus, dataPid: pushPid,
                         byteCount: pushByteCount, chanNum: pushChannel};
  assign unusedWdata = ^regWdata[31:2];

  rxq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid),
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .regByteEn(regByteEn), .clearBits(regWdata[1:0]),
    .count(count), .headStatus(headEntry.pktStatus),
    .strobe(strobe), .flagBits(flagBits), .notEmpty(notEmpty),
    .popIrq(popIrq), .irqPending(irqPending), .overflowFlag(overflowFlag)
  );

  rxq_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushEntry(pushEntry),
    .flagBits(flagBits), .count(count), .headEntry(headEntry),
    .rdata(regRdata)
  );

endmodule

// File: tb/rx_event_queue_tb.sv
`timescale 1ns/1ps
module rx_event_queue_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0;
  logic [3:0]  pushStatus = '0;
  logic [1:0]  pushPid = '0;
  logic [10:0] pushByteCount = '0;
  logic [3:0]  pushChannel = '0;
  logic        regSel = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        notEmpty, popIrq, irqPending, overflowFlag;

  int checks = 0;
  int errors = 0;
  logic [31:0] capData;
  logic        capIrq;

  always #2.5 clk = ~clk;

  rx_event_queue dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushStatus(pushStatus),
    .pushPid(pushPid), .pushByteCount(pushByteCount), .pushChannel(pushChannel),
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(regRdata),
    .notEmpty(notEmpty), .popIrq(popIrq), .irqPending(irqPending),
    .overflowFlag(overflowFlag)
  );

  // {status[3:0], pid[1:0], byteCount[10:0], channel[3:0], expectIrq}
  localparam logic [21:0] VEC [8] = '{
    {4'b0010, 2'b00, 11'd64,   4'd1,  1'b0},
    {4'b0011, 2'b10, 11'd0,    4'd2,  1'b1},
    {4'b0101, 2'b01, 11'd2047, 4'd15, 1'b1},
    {4'b0111, 2'b00, 11'd5,    4'd0,  1'b1},
    {4'b1111, 2'b11, 11'd1023, 4'd7,  1'b0},
    {4'b0010, 2'b10, 11'd1,    4'd9,  1'b0},
    {4'b0011, 2'b01, 11'd1536, 4'd3,  1'b1},
    {4'b0000, 2'b00, 11'd0,    4'd0,  1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setEntry(input logic [20:0] e);
    {pushStatus, pushPid, pushByteCount, pushChannel} = e;
  endtask

  // Called at a negedge; captures registered outputs one cycle later.
  task automatic access(input logic wr, input logic [7:0] addr,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic alsoPush, input logic [20:0] e);
    regSel = 1'b1; regWrite = wr; regAddr = addr; regByteEn = be; regWdata = wd;
    pushValid = alsoPush; setEntry(e);
    @(negedge clk);
    capData = regRdata; capIrq = popIrq;
    regSel = 1'b0; regWrite = 1'b0; pushValid = 1'b0;
  endtask

  task automatic push(input logic [20:0] e);
    pushValid = 1'b1; setEntry(e);
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr);
    access(1'b0, addr, 4'hF, 32'h0, 1'b0, 21'h0);
  endtask

  task automatic wrFlags(input logic [31:0] wd);
    access(1'b1, 8'h24, 4'hF, wd, 1'b0, 21'h0);
  endtask

  initial begin
    logic pend;
    pend = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11", "notEmpty", {31'h0, notEmpty}, 32'h0);
    check("R11", "rdata", regRdata, 32'h0);
    check("R11", "popIrq", {31'h0, popIrq}, 32'h0);
    check("R11", "irqPending", {31'h0, irqPending}, 32'h0);
    check("R11", "overflow", {31'h0, overflowFlag}, 32'h0);

    // R7 pop on empty
    rd(8'h20);
    check("R7", "empty pop data", capData, 32'h0);
    check("R7", "empty pop irq", {31'h0, capIrq}, 32'h0);
    check("R7", "empty after pop", {31'h0, notEmpty}, 32'h0);

    // Fill from table, R6 non-empty
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][21:1]);
      check("R6", "notEmpty after push", {31'h0, notEmpty}, 32'h1);
    end
    check("R8", "no overflow at full", {31'h0, overflowFlag}, 32'h0);
    push(21'h1ABCD);
    check("R8", "overflow after full push", {31'h0, overflowFlag}, 32'h1);
    rd(8'h24);
    check("R8", "flag reg bit1", capData, 32'h2);

    // R1 peek twice returns head unchanged
    rd(8'h1C);
    check("R1", "peek head", capData, {11'h0, VEC[0][21:1]});
    rd(8'h1C);
    check("R1", "second peek", capData, {11'h0, VEC[0][21:1]});

    // R2/R3/R4/R12 pop all in order
    for (int i = 0; i < 8; i++) begin
      rd(8'h20);
      check("R2", "pop data", capData, {11'h0, VEC[i][21:1]});
      check("R4", "pop irq", {31'h0, capIrq}, {31'h0, VEC[i][0]});
      if (VEC[i][0]) pend = 1'b1;
    end
    check("R12", "dropped push not stored", {31'h0, notEmpty}, 32'h0);
    check("R4", "irqPending", {31'h0, irqPending}, {31'h0, pend});
    @(negedge clk);
    check("R4", "pulse one cycle", {31'h0, popIrq}, 32'h0);

    // R10 partial accesses ignored
    push({4'b0011, 2'b10, 11'd77, 4'd4});
    access(1'b0, 8'h20, 4'h7, 32'h0, 1'b0, 21'h0);
    check("R10", "partial read data", capData, 32'h0);
    check("R10", "partial read no pop", {31'h0, notEmpty}, 32'h1);
    access(1'b1, 8'h24, 4'h3, 32'h3, 1'b0, 21'h0);
    check("R10", "partial write pending", {31'h0, irqPending}, 32'h1);
    check("R10", "partial write overflow", {31'h0, overflowFlag}, 32'h1);

    // R5 write-1-to-clear
    wrFlags(32'h0);
    check("R5", "write 0 keeps pending", {31'h0, irqPending}, 32'h1);
    wrFlags(32'h1);
    check("R5", "write 1 clears pending", {31'h0, irqPending}, 32'h0);
    check("R5", "overflow untouched", {31'h0, overflowFlag}, 32'h1);
    wrFlags(32'h2);
    check("R8", "overflow cleared", {31'h0, overflowFlag}, 32'h0);
    rd(8'h24);
    check("R5", "flag reg zero", capData, 32'h0);

    // R9 push+pop with one entry
    access(1'b0, 8'h20, 4'hF, 32'h0, 1'b1, {4'b0010, 2'b00, 11'd300, 4'd6});
    check("R9", "pushpop returns old head", capData, {11'h0, 4'b0011, 2'b10, 11'd77, 4'd4});
    check("R4", "pushpop irq", {31'h0, capIrq}, 32'h1);
    check("R9", "still one entry", {31'h0, notEmpty}, 32'h1);
    rd(8'h20);
    check("R9", "new entry", capData, {11'h0, 4'b0010, 2'b00, 11'd300, 4'd6});
    check("R9", "empty afterwards", {31'h0, notEmpty}, 32'h0);

    // R9 push+pop at full
    for (int i = 0; i < 8; i++) push({4'b0010, 2'b00, 11'(i), 4'd0});
    access(1'b0, 8'h20, 4'hF, 32'h0, 1'b1, {4'b0010, 2'b01, 11'd100, 4'd12});
    check("R9", "full pushpop head", capData, {11'h0, 4'b0010, 2'b00, 11'd0, 4'd0});
    check("R9", "full pushpop no overflow", {31'h0, overflowFlag}, 32'h0);
    for (int i = 1; i < 8; i++) begin
      rd(8'h20);
      check("R12", "order after wrap", capData, {11'h0, 4'b0010, 2'b00, 11'(i), 4'd0});
    end
    rd(8'h20);
    check("R9", "accepted full push last", capData, {11'h0, 4'b0010, 2'b01, 11'd100, 4'd12});
    check("R6", "empty at end", {31'h0, notEmpty}, 32'h0);
    rd(8'h1C);
    check("R7", "peek empty", capData, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule